// File: doc/BRIEF.md
# Pending Interrupt Priority Arbiter

This block chooses which of a set of interrupt sources the processor should be offered next. Each source brings three things from an external register bank: an enable bit, a pending bit and an 8-bit priority. A smaller number means more urgent. A balanced tree of comparators reduces all sources that are both enabled and pending to a single winner in one cycle. On equal priority, the lower-numbered source wins.

The winner then has to pass two thresholds. The first is a programmable priority mask held inside the block. The second is the priority of the interrupt the processor is already servicing. The block registers two outputs: the selected interrupt number and the processor request line. When nothing qualifies, the selected number is the reserved value 1023. A global distribution enable and a processor-side enable can each force the outputs to the idle state.

Top module: `irq_prio_arbiter`

## Requirements
- R1: A source takes part in arbitration only when its enable bit and its pending bit are both 1. If only one of the two is set, the source has no effect on the outputs.
- R2: Among qualifying sources, the one with the numerically smallest 8-bit priority is selected. Source k's priority occupies bits [8k+7:8k] of `src_prio`.
- R3: When qualifying sources share the smallest priority, the lowest source number is selected. This holds for every source number, including 0 and the highest one.
- R4: When either `dist_en` or `cpu_en` is 0, `irq_req` is 0 and `sel_id` is 1023.
- R5: When the winning priority is numerically greater than the mask, `irq_req` is 0 and `sel_id` is 1023. A winning priority equal to the mask passes.
- R6: When the winner passes the mask, `sel_id` is its source number. `irq_req` is 1 only if the winner's priority is strictly less than the 9-bit `run_prio`. A `run_prio` of 0x100 means nothing is running.
- R7: With no qualifying source, `sel_id` is 1023 and `irq_req` is 0.
- R8: The mask register resets to 0xF0. A cycle with `mask_we` high loads `mask_wdata` into it at that clock edge. The outputs use the new mask from the following edge.
- R9: Both outputs are registered. They reflect the inputs sampled at the previous rising edge, and they hold 1023 and 0 while `rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dist_en | input | 1 | Global distribution enable |
| cpu_en | input | 1 | Processor-side enable |
| src_enable | input | 96 | Per-source enable bits |
| src_pending | input | 96 | Per-source pending bits |
| src_prio | input | 768 | Per-source 8-bit priorities, source k at [8k+7:8k] |
| run_prio | input | 9 | Priority of the interrupt being serviced, 0x100 when idle |
| mask_we | input | 1 | Load strobe for the priority mask |
| mask_wdata | input | 8 | New priority mask value |
| sel_id | output | 10 | Selected source number, 1023 when none |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
Some properties are checked by assertions on every cycle. These are:
- the selected source was enabled and pending one cycle earlier;
- its priority passed the previous mask;
- a raised request implies a strictly smaller priority than the previous running priority and a real source number;
- a cleared enable forces the idle outputs.

The assertions cannot show that the selected source is the best one. Ordering by priority, the lower-number tie-break, the reset value of the mask and the two-edge latency of a mask write are shown only by the bench. It compares `sel_id` and `irq_req` against a linear search over its own copy of the inputs, using directed corner cases and random updates.

// File: rtl/pia_pkg.sv
package pia_pkg;

    localparam int NUM_SRC  = 96;
    localparam int PRIO_W   = 8;
    localparam int ID_W     = 10;
    localparam int NONE_ID  = 1023;
    localparam logic [PRIO_W-1:0] MASK_RST = 8'hF0;

    typedef struct packed {
        logic              valid;
        logic [PRIO_W-1:0] prio;
        logic [ID_W-1:0]   id;
    } cand_t;

    // lo carries the lower source numbers, so it keeps ties
    function automatic cand_t pick_better(cand_t lo, cand_t hi);
        if (hi.valid && (!lo.valid || (hi.prio < lo.prio)))
            return hi;
        return lo;
    endfunction

endpackage

// File: rtl/pia_leaf_gen.sv
module pia_leaf_gen
    import pia_pkg::*;
#(
    parameter int N      = NUM_SRC,
    parameter int LEAVES = 128
) (
    input  logic [N-1:0]        enable_i,
    input  logic [N-1:0]        pending_i,
    input  logic [N*PRIO_W-1:0] prio_i,
    output cand_t [LEAVES-1:0]  leaf_o
);

    for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
        if (k < N) begin : g_real
            assign leaf_o[k].valid = enable_i[k] & pending_i[k];
            assign leaf_o[k].prio  = prio_i[k*PRIO_W +: PRIO_W];
            assign leaf_o[k].id    = ID_W'(k);
        end else begin : g_pad
            assign leaf_o[k] = '0;
        end
    end

endmodule

// File: rtl/pia_min_tree.sv
module pia_min_tree
    import pia_pkg::*;
#(
    parameter int LEVELS = 7,
    localparam int LEAVES = 1 << LEVELS
) (
    input  cand_t [LEAVES-1:0] leaf_i,
    output cand_t              best_o
);

    for (genvar l = 0; l <= LEVELS; l++) begin : lv
        cand_t nd [1 << l];
        for (genvar j = 0; j < (1 << l); j++) begin : g_node
            if (l == LEVELS) begin : g_in
                assign nd[j] = leaf_i[j];
            end else begin : g_cmp
                assign nd[j] = pick_better(lv[l+1].nd[2*j], lv[l+1].nd[2*j+1]);
            end
        end
    end

    assign best_o = lv[0].nd[0];

    always_comb begin
        a_root_id_ok_r2: assert (!best_o.valid || (int'(best_o.id) < LEAVES))
            else $error("root id out of range");
    end

endmodule

// File: rtl/pia_gate.sv
module pia_gate
    import pia_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              dist_en,
    input  logic              cpu_en,
    input  cand_t             best_i,
    input  logic [PRIO_W-1:0] mask_i,
    input  logic [PRIO_W:0]   run_prio_i,
    output logic [ID_W-1:0]   sel_id_o,
    output logic              irq_req_o
);

    logic [ID_W-1:0] id_d;
    logic            req_d;

    always_comb begin
        id_d  = ID_W'(NONE_ID);
        req_d = 1'b0;
        if (dist_en && cpu_en && best_i.valid && (best_i.prio <= mask_i)) begin
            id_d  = best_i.id;
            req_d = ({1'b0, best_i.prio} < run_prio_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_id_o  <= ID_W'(NONE_ID);
            irq_req_o <= 1'b0;
        end else begin
            sel_id_o  <= id_d;
            irq_req_o <= req_d;
        end
    end

    p_off_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (!dist_en || !cpu_en) |=> (!irq_req_o && (sel_id_o == ID_W'(NONE_ID))))
        else $error("disabled but outputs not idle");

    p_req_has_id_r6: assert property (@(posedge clk) disable iff (rst)
        irq_req_o |-> (sel_id_o != ID_W'(NONE_ID)))
        else $error("request without selected id");

endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
    import pia_pkg::*;
#(
    parameter int N = NUM_SRC,
    localparam int LEVELS = $clog2(N),
    localparam int LEAVES = 1 << LEVELS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                dist_en,
    input  logic                cpu_en,
    input  logic [N-1:0]        src_enable,
    input  logic [N-1:0]        src_pending,
    input  logic [N*PRIO_W-1:0] src_prio,
    input  logic [PRIO_W:0]     run_prio,
    input  logic                mask_we,
    input  logic [PRIO_W-1:0]   mask_wdata,
    output logic [ID_W-1:0]     sel_id,
    output logic                irq_req
);

    cand_t [LEAVES-1:0] leaves;
    cand_t              best;
    logic [PRIO_W-1:0]  mask_q;

    always_ff @(posedge clk) begin
        if (rst)          mask_q <= MASK_RST;
        else if (mask_we) mask_q <= mask_wdata;
    end

    pia_leaf_gen #(.N(N), .LEAVES(LEAVES)) u_leaf (
        .enable_i  (src_enable),
        .pending_i (src_pending),
        .prio_i    (src_prio),
        .leaf_o    (leaves)
    );

    pia_min_tree #(.LEVELS(LEVELS)) u_tree (
        .leaf_i (leaves),
        .best_o (best)
    );

    pia_gate u_gate (
        .clk        (clk),
        .rst        (rst),
        .dist_en    (dist_en),
        .cpu_en     (cpu_en),
        .best_i     (best),
        .mask_i     (mask_q),
        .run_prio_i (run_prio),
        .sel_id_o   (sel_id),
        .irq_req_o  (irq_req)
    );

    // Checking state: copies of the inputs seen at the previous edge
    logic [N-1:0]        qual_q;
    logic [N*PRIO_W-1:0] prio_q;
    logic [PRIO_W:0]     run_q;
    logic [PRIO_W-1:0]   sel_prio;
    logic                sel_real;
    logic [LEVELS-1:0]   sel_idx;

    always_ff @(posedge clk) begin
        qual_q <= src_enable & src_pending;
        prio_q <= src_prio;
        run_q  <= run_prio;
    end

    assign sel_real = (int'(sel_id) < N);
    assign sel_idx  = sel_id[LEVELS-1:0];
    assign sel_prio = sel_real ? prio_q[int'(sel_idx)*PRIO_W +: PRIO_W] : '0;

    p_sel_qualified_r1: assert property (@(posedge clk) disable iff (rst)
        (sel_id != ID_W'(NONE_ID)) |-> (sel_real && qual_q[sel_idx]))
        else $error("selected source was not enabled and pending");

    p_sel_under_mask_r5: assert property (@(posedge clk) disable iff (rst)
        (sel_id != ID_W'(NONE_ID)) |-> (sel_prio <= $past(mask_q)))
        else $error("selected priority exceeds mask");

    p_req_strict_r6: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> ({1'b0, sel_prio} < run_q))
        else $error("request not below running priority");

endmodule

// File: tb/tb_irq_prio_arbiter.sv
module tb_irq_prio_arbiter;

    localparam int N  = 96;
    localparam int PW = 8;

    logic            clk = 1'b0;
    logic            rst;
    logic            dist_en, cpu_en;
    logic [N-1:0]    src_enable, src_pending;
    logic [N*PW-1:0] src_prio;
    logic [PW:0]     run_prio;
    logic            mask_we;
    logic [PW-1:0]   mask_wdata;
    logic [9:0]      sel_id;
    logic            irq_req;

    int n_chk = 0;
    int n_bad = 0;
    int mask_m;
    bit done = 0;

    always #5 clk = ~clk;

    irq_prio_arbiter dut (
        .clk(clk), .rst(rst), .dist_en(dist_en), .cpu_en(cpu_en),
        .src_enable(src_enable), .src_pending(src_pending), .src_prio(src_prio),
        .run_prio(run_prio), .mask_we(mask_we), .mask_wdata(mask_wdata),
        .sel_id(sel_id), .irq_req(irq_req)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic void model(output int id, output int rq);
        int best = -1;
        int bp   = 0;
        id = 1023;
        rq = 0;
        for (int k = 0; k < N; k++) begin
            if (src_enable[k] && src_pending[k]) begin
                int p = int'(src_prio[k*PW +: PW]);
                if (best < 0 || p < bp) begin
                    best = k;
                    bp   = p;
                end
            end
        end
        if (!dist_en || !cpu_en || best < 0 || bp > mask_m) return;
        id = best;
        rq = (bp < int'(run_prio)) ? 1 : 0;
    endfunction

    task automatic step_check(string tag);
        int e_id, e_rq;
        model(e_id, e_rq);
        @(posedge clk);
        #1;
        chk({tag, " id"}, int'(sel_id), e_id);
        chk({tag, " req"}, int'(irq_req), e_rq);
        @(negedge clk);
    endtask

    task automatic set_src(int k, bit en, bit pd, int p);
        src_enable[k]        = en;
        src_pending[k]       = pd;
        src_prio[k*PW +: PW] = PW'(p);
    endtask

    task automatic clear_all();
        src_enable  = '0;
        src_pending = '0;
        src_prio    = '0;
    endtask

    task automatic write_mask(int v);
        mask_we    = 1'b1;
        mask_wdata = PW'(v);
        @(posedge clk);
        #1;
        mask_m = v;
        @(negedge clk);
        mask_we = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int e_id, e_rq;
        void'($urandom(32'h5eed_1234));
        rst = 1'b1; dist_en = 1'b1; cpu_en = 1'b1;
        clear_all();
        run_prio = 9'h100; mask_we = 1'b0; mask_wdata = '0;
        mask_m = 8'hF0;
        set_src(4, 1, 1, 1);
        repeat (3) @(negedge clk);
        // R9: outputs idle while reset is held, even with a qualifying source
        chk("R9 reset id", int'(sel_id), 1023);
        chk("R9 reset req", int'(irq_req), 0);
        rst = 1'b0;
        clear_all();
        step_check("R7 nothing pending");

        set_src(5, 1, 1, 8'h10);
        step_check("R6 single source");
        set_src(5, 0, 1, 8'h10);
        step_check("R1 pending not enabled");
        set_src(5, 1, 0, 8'h10);
        step_check("R1 enabled not pending");

        clear_all();
        set_src(3, 1, 1, 8'h20);
        set_src(40, 1, 1, 8'h08);
        step_check("R2 smaller prio wins");
        set_src(7, 1, 1, 8'h08);
        set_src(90, 1, 1, 8'h08);
        step_check("R3 tie lower id");
        clear_all();
        set_src(95, 1, 1, 8'h01);
        set_src(0, 1, 1, 8'h01);
        step_check("R3 tie id0 vs top");
        set_src(0, 0, 0, 8'h01);
        step_check("R3 top source alone");

        // R9: change inputs, output must hold until next edge
        model(e_id, e_rq);
        set_src(20, 1, 1, 8'h00);
        #1;
        chk("R9 hold before edge", int'(sel_id), e_id);
        step_check("R9 after edge");

        clear_all();
        set_src(9, 1, 1, 8'h08);
        run_prio = 9'h008;
        step_check("R6 equal running no req");
        run_prio = 9'h009;
        step_check("R6 below running req");
        run_prio = 9'h100;

        // R8: reset mask 0xF0 lets 0xF0 through, blocks 0xF1
        clear_all();
        set_src(11, 1, 1, 8'hF0);
        step_check("R8 R5 prio equal reset mask");
        set_src(11, 1, 1, 8'hF1);
        step_check("R8 R5 prio above reset mask");
        set_src(11, 1, 1, 8'h20);
        write_mask(8'h10);
        step_check("R8 R5 after mask write");
        write_mask(8'h20);
        step_check("R5 equal written mask");
        write_mask(8'hF0);

        dist_en = 1'b0;
        step_check("R4 dist disabled");
        dist_en = 1'b1; cpu_en = 1'b0;
        step_check("R4 cpu disabled");
        cpu_en = 1'b1;

        for (int it = 0; it < 400; it++) begin
            for (int k = 0; k < N; k++) begin
                if (($urandom % 8) == 0) begin
                    set_src(k, ($urandom % 2) == 1, ($urandom % 3) == 0,
                            ($urandom % 4 == 0) ? $urandom % 256 : $urandom % 16);
                end
            end
            if (($urandom % 10) == 0) run_prio = 9'($urandom % 257);
            if (($urandom % 20) == 0) dist_en = ($urandom % 4) != 0;
            if (($urandom % 20) == 0) cpu_en  = ($urandom % 4) != 0;
            if (($urandom % 25) == 0) write_mask($urandom % 256);
            step_check("R2 random vs linear search");
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule